// File: doc/BRIEF.md
# Integer ALU with control decoder

This block is the arithmetic and logic stage of a simple single-issue integer datapath. A decoder turns the 6-bit primary opcode and the 6-bit function code of the current instruction into a two-part control word: an invert-B bit and a 2-bit operation select. A 32-bit ALU then uses that control word to produce a bitwise AND, a bitwise OR, a sum, a difference, or a signed set-on-less-than value.

The ALU is built as a ripple chain of one-bit slices. When invert-B is set, every slice complements its B bit and the carry into bit 0 is forced high, so the chain computes A minus B in two's complement. The set-on-less-than result reuses this subtraction. Its sign is corrected by the signed overflow of the chain and fed back into bit 0 of the result.

The result, a zero flag and the zero flag's complement are registered on the rising clock edge. The instruction fetch stage uses these flags to resolve a branch taken when its operands differ. All outputs appear one cycle after the inputs are applied.

Top module: `alu_unit`

## Requirements
- R1: While rst_ni is low, result_o is 0, zero_o is 1 and not_zero_o is 0. Otherwise the outputs reflect the inputs present at the previous rising edge of clk_i.
- R2: Opcode 000000 with function code 100100 yields the bitwise AND of a_i and b_i.
- R3: Opcode 000000 with function code 100101 yields the bitwise OR of a_i and b_i.
- R4: Opcode 000000 with function code 100000 yields a_i plus b_i modulo 2^32.
- R5: Opcode 000000 with function code 100010 yields a_i minus b_i modulo 2^32.
- R6: Opcode 000000 with function code 101010 yields 1 when a_i is less than b_i as signed 32-bit numbers and 0 otherwise, including when the difference overflows. Bits 31..1 are always 0.
- R7: Opcodes 100011 (load word) and 101011 (store word) yield a_i plus b_i for every value of funct_i.
- R8: Opcode 000100 (branch if not equal) yields a_i minus b_i, so zero_o is 1 exactly when a_i equals b_i.
- R9: zero_o is 1 exactly when all 32 bits of result_o are 0, and not_zero_o is always the complement of zero_o.
- R10: Any opcode not listed above, and opcode 000000 with a function code not listed above, yields a_i plus b_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; outputs update on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 6 | Primary opcode of the instruction |
| funct_i | input | 6 | Function code, used when the opcode is 000000 |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Registered ALU result |
| zero_o | output | 1 | Registered flag: result is all zeros |
| not_zero_o | output | 1 | Complement of zero_o |

## Verification
Several properties are checked on every cycle:
- The zero flag and its complement stay consistent with the registered result.
- The set-on-less-than result only ever uses bit 0.
- AND and OR results equal the bitwise functions of the operands sampled one edge earlier.
- A branch-if-not-equal with equal operands always raises the zero flag.

The arithmetic values need the bench's scenarios:
- carry wrap-around on add and load/store;
- the signed compare when the subtraction overflows;
- the funct code being ignored outside opcode 000000;
- the add fallback for undefined codes.

Each of these is checked against an independent model fed by directed corner operands and random operands.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned CODE_W = 6;

  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_ADD = 2'b10,
    OP_SLT = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic    inv_b;
    alu_op_e op;
  } alu_ctrl_t;

  localparam logic [CODE_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [CODE_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [CODE_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [CODE_W-1:0] OPC_BNE   = 6'b000100;

  localparam logic [CODE_W-1:0] FN_ADD = 6'b100000;
  localparam logic [CODE_W-1:0] FN_SUB = 6'b100010;
  localparam logic [CODE_W-1:0] FN_AND = 6'b100100;
  localparam logic [CODE_W-1:0] FN_OR  = 6'b100101;
  localparam logic [CODE_W-1:0] FN_SLT = 6'b101010;

endpackage

// File: rtl/alu_ctrl_dec.sv
`timescale 1ns/1ps
module alu_ctrl_dec
  import alu_pkg::*;
(
  input  logic [CODE_W-1:0] opcode_i,
  input  logic [CODE_W-1:0] funct_i,
  output alu_ctrl_t         ctrl_o
);

  alu_ctrl_t rtype_ctrl;

  // function-code half, only meaningful for opcode 000000
  always_comb begin
    unique case (funct_i)
      FN_ADD:  rtype_ctrl = '{inv_b: 1'b0, op: OP_ADD};
      FN_SUB:  rtype_ctrl = '{inv_b: 1'b1, op: OP_ADD};
      FN_AND:  rtype_ctrl = '{inv_b: 1'b0, op: OP_AND};
      FN_OR:   rtype_ctrl = '{inv_b: 1'b0, op: OP_OR};
      FN_SLT:  rtype_ctrl = '{inv_b: 1'b1, op: OP_SLT};
      default: rtype_ctrl = '{inv_b: 1'b0, op: OP_ADD}; // R10 fallback
    endcase
  end

  always_comb begin
    unique case (opcode_i)
      OPC_RTYPE: ctrl_o = rtype_ctrl;
      OPC_LOAD,
      OPC_STORE: ctrl_o = '{inv_b: 1'b0, op: OP_ADD};
      OPC_BNE:   ctrl_o = '{inv_b: 1'b1, op: OP_ADD};
      default:   ctrl_o = '{inv_b: 1'b0, op: OP_ADD};
    endcase
  end

  // slt needs the subtracting chain to form its sign
  always_comb begin
    if (ctrl_o.op == OP_SLT) begin
      p_slt_inverts_r6: assert (ctrl_o.inv_b)
        else $error("slt decoded without invert-B");
    end
  end

endmodule

// File: rtl/alu_bit_slice.sv
`timescale 1ns/1ps
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    inv_b_i,
  input  logic    carry_i,
  input  logic    less_i,
  input  alu_op_e op_i,
  output logic    sum_o,
  output logic    carry_o,
  output logic    res_o
);

  logic b_eff;

  assign b_eff   = b_i ^ inv_b_i;
  assign sum_o   = a_i ^ b_eff ^ carry_i;
  assign carry_o = (a_i & b_eff) | (a_i & carry_i) | (b_eff & carry_i);

  always_comb begin
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_ADD: res_o = sum_o;
      OP_SLT: res_o = less_i;
      default: res_o = sum_o;
    endcase
  end

endmodule

// File: rtl/alu_core.sv
`timescale 1ns/1ps
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  alu_ctrl_t        ctrl_i,
  output logic [WIDTH-1:0] res_o
);

  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] less;
  logic             ovf;
  logic             set_lt;

  // inverting B plus a carry-in of one forms -B
  assign carry[0] = ctrl_i.inv_b;

  // signed overflow: carry into MSB differs from carry out
  assign ovf    = carry[MSB] ^ carry[WIDTH];
  assign set_lt = sum[MSB] ^ ovf;

  assign less = {{(WIDTH-1){1'b0}}, set_lt};

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bit_slice u_slice (
      .a_i     (a_i[i]),
      .b_i     (b_i[i]),
      .inv_b_i (ctrl_i.inv_b),
      .carry_i (carry[i]),
      .less_i  (less[i]),
      .op_i    (ctrl_i.op),
      .sum_o   (sum[i]),
      .carry_o (carry[i+1]),
      .res_o   (res_o[i])
    );
  end

endmodule

// File: rtl/alu_unit.sv
`timescale 1ns/1ps
module alu_unit
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] opcode_i,
  input  logic [CODE_W-1:0] funct_i,
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              zero_o,
  output logic              not_zero_o
);

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] res_d;
  logic [WIDTH-1:0] res_q;
  logic             zero_q;

  alu_ctrl_dec u_dec (
    .opcode_i (opcode_i),
    .funct_i  (funct_i),
    .ctrl_o   (ctrl)
  );

  alu_core #(.WIDTH(WIDTH)) u_core (
    .a_i    (a_i),
    .b_i    (b_i),
    .ctrl_i (ctrl),
    .res_o  (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      zero_q <= 1'b1;
    end else begin
      res_q  <= res_d;
      zero_q <= ~|res_d;
    end
  end

  assign result_o   = res_q;
  assign zero_o     = zero_q;
  assign not_zero_o = ~zero_q;

  p_zero_means_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> (result_o == '0));

  p_nonzero_means_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zero_o |-> (result_o != '0));

  p_flag_pair_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o != not_zero_o);

  p_slt_single_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == OPC_RTYPE && funct_i == FN_SLT) |=> (result_o[WIDTH-1:1] == '0));

  p_and_value_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == OPC_RTYPE && funct_i == FN_AND) |=> (result_o == ($past(a_i) & $past(b_i))));

  p_or_value_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == OPC_RTYPE && funct_i == FN_OR) |=> (result_o == ($past(a_i) | $past(b_i))));

  p_bne_equal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == OPC_BNE && a_i == b_i) |=> zero_o);

endmodule

// File: tb/alu_unit_test.sv
`timescale 1ns/1ps
module alu_unit_test;
  import alu_pkg::*;

  typedef struct {
    logic [31:0] res;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opcode = '0;
  logic [5:0]  funct = '0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [31:0] result;
  logic        zero;
  logic        not_zero;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  alu_unit uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .opcode_i   (opcode),
    .funct_i    (funct),
    .a_i        (a),
    .b_i        (b),
    .result_o   (result),
    .zero_o     (zero),
    .not_zero_o (not_zero)
  );

  function automatic logic [31:0] model(logic [5:0] op, logic [5:0] fn,
                                        logic [31:0] x, logic [31:0] y);
    if (op == 6'b000000) begin
      case (fn)
        6'b100100: return x & y;
        6'b100101: return x | y;
        6'b100010: return x - y;
        6'b101010: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
        default:   return x + y;
      endcase
    end
    if (op == 6'b000100) return x - y;
    return x + y;
  endfunction

  task automatic drive(logic [5:0] op, logic [5:0] fn, logic [31:0] x,
                       logic [31:0] y, string tag);
    exp_t e;
    @(negedge clk);
    opcode = op; funct = fn; a = x; b = y;
    e.res = model(op, fn, x, y);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: result is captured on the posedge after the drive
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_tests++;
        if (result !== e.res || zero !== (e.res == 32'd0) || not_zero !== (e.res != 32'd0)) begin
          n_fail++;
          $display("FAIL %s: result=%h zero=%b nz=%b expected result=%h zero=%b",
                   e.tag, result, zero, not_zero, e.res, e.res == 32'd0);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    opcode = 6'b000000; funct = 6'b100000; a = 32'h1234; b = 32'h1;
    @(negedge clk);
    n_tests++;
    if (result !== 32'd0 || zero !== 1'b1 || not_zero !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: reset result=%h zero=%b nz=%b expected 0/1/0", result, zero, not_zero);
    end
    rst_n = 1'b1;

    // R2 and R3 patterns
    drive(6'b000000, 6'b100100, 32'hF0F0_A5A5, 32'hFF00_0FF0, "R2 and");
    drive(6'b000000, 6'b100100, 32'h5555_5555, 32'hAAAA_AAAA, "R2 and disjoint");
    drive(6'b000000, 6'b100101, 32'h5555_5555, 32'hAAAA_AAAA, "R3 or");
    drive(6'b000000, 6'b100101, 32'h0, 32'h0, "R3 or zero");
    // R4 add with wrap
    drive(6'b000000, 6'b100000, 32'hFFFF_FFFF, 32'h1, "R4 add wrap");
    drive(6'b000000, 6'b100000, 32'h7FFF_FFFF, 32'h1, "R4 add");
    // R5 sub
    drive(6'b000000, 6'b100010, 32'h0, 32'h1, "R5 sub borrow");
    drive(6'b000000, 6'b100010, 32'h1234_5678, 32'h1234_5678, "R5 sub equal");
    // R6 slt corners including overflow
    drive(6'b000000, 6'b101010, 32'h8000_0000, 32'h7FFF_FFFF, "R6 slt ovf min<max");
    drive(6'b000000, 6'b101010, 32'h7FFF_FFFF, 32'h8000_0000, "R6 slt ovf max>min");
    drive(6'b000000, 6'b101010, 32'hFFFF_FFFF, 32'h0, "R6 slt -1<0");
    drive(6'b000000, 6'b101010, 32'h5, 32'h5, "R6 slt equal");
    drive(6'b000000, 6'b101010, 32'h3, 32'h9, "R6 slt small");
    // R7 load/store ignore funct
    drive(6'b100011, 6'b100010, 32'h1000, 32'h10, "R7 load funct ignored");
    drive(6'b101011, 6'b100100, 32'hFFFF_FFF0, 32'h10, "R7 store wrap");
    // R8 branch compare
    drive(6'b000100, 6'b100101, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R8 bne equal");
    drive(6'b000100, 6'b000000, 32'hDEAD_BEEF, 32'hDEAD_BEEE, "R8 bne differ");
    // R9 flag both ways
    drive(6'b000000, 6'b100100, 32'hFFFF_0000, 32'h0000_FFFF, "R9 zero result");
    drive(6'b000000, 6'b100101, 32'h0, 32'h8000_0000, "R9 msb only");
    // R10 fallback
    drive(6'b111111, 6'b100010, 32'h20, 32'h3, "R10 unknown opcode");
    drive(6'b000000, 6'b101011, 32'h20, 32'h3, "R10 unknown funct");

    for (int i = 0; i < 300; i++) begin
      logic [31:0] x, y;
      int sel;
      x = $urandom; y = $urandom;
      if (i % 7 == 0) y = x;
      sel = i % 9;
      case (sel)
        0: drive(6'b000000, 6'b100100, x, y, "R2 rand");
        1: drive(6'b000000, 6'b100101, x, y, "R3 rand");
        2: drive(6'b000000, 6'b100000, x, y, "R4 rand");
        3: drive(6'b000000, 6'b100010, x, y, "R5 rand");
        4: drive(6'b000000, 6'b101010, x, y, "R6 rand");
        5: drive(6'b100011, 6'($urandom), x, y, "R7 rand load");
        6: drive(6'b101011, 6'($urandom), x, y, "R7 rand store");
        7: drive(6'b000100, 6'($urandom), x, y, "R8 rand");
        default: drive(6'b010101, 6'($urandom), x, y, "R10 rand");
      endcase
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule